// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Styles

The block gives a chip sixteen general-purpose pins behind a small 32-bit memory-mapped register bus addressed by byte offset, with separate read and write strobes. Software sets a per-line direction and output value, reads the pin levels through a two-flop synchronizer, and chooses for each line one of five detection styles. Any detection latches a per-line pending bit. Thirteen of those bits leave the block as level-high interrupt requests to a parent interrupt controller.

A pin drives its output value only when its direction bit is 0. After reset every pin is an input. Software clears a pending bit by writing a 1 to it. Under a level style the bit sets again on every clock for as long as the pin stays in the active state. The bus has no back-pressure: a write takes effect at the clock edge where `bus_wr` is high. Read data shows up on `bus_rdata` one clock after the edge that samples `bus_rd`, and it holds until the next read.

Top module: `pio_irq_ctrl`

## Requirements
- R1: After reset the output register reads 0, direction reads 0xFFFF, both style registers, the pending register and the clock-setup register read 0, `pad_oe` is 0 and `irq` is 0.
- R2: Byte offsets: 0x00 output, 0x04 direction, 0x08 input, 0x0C pending, 0x10 styles of lines 0–7, 0x14 styles of lines 8–15, 0x18 clock setup, 0x1C filter select. Read data is valid one clock after `bus_rd` is sampled. Any other offset reads 0.
- R3: For each line n, direction bit n = 1 gives `pad_oe[n]` = 0. Direction bit n = 0 gives `pad_oe[n]` = 1, and `pad_out[n]` follows output bit n.
- R4: The input register shows `pad_in` delayed by two synchronizer flops. Writes to offset 0x08 are ignored. A detection sets the pending bit on the third clock edge after the pin changes.
- R5: The style of line n sits in bits [3n+2:3n] of the register at 0x10 (n = 0–7), or at 0x14 with n replaced by n−8. Bits 31:24 of both style registers read 0.
- R6: Code 0 detects a high level and code 1 a low level. The pending bit sets on every clock while the level holds, so a write-1 clear has no lasting effect during that time.
- R7: Code 2 detects a rising edge, code 3 a falling edge and code 4 either edge. Each edge sets the pending bit once.
- R8: Codes 5, 6 and 7 never set a pending bit.
- R9: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A detection in the same cycle as a clear wins.
- R10: `irq[k]` equals pending bit k for k = 0–12. Lines 13–15 latch pending bits that can be read, but they have no interrupt output.
- R11: The clock-setup and filter-select registers store all 32 written bits, read them back and have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one clock after the read |
| pad_in | input | 16 | Pin levels, asynchronous |
| pad_out | output | 16 | Value to drive on each pin |
| pad_oe | output | 16 | Pin driver enable, 1 = drive |
| irq | output | 13 | Level-high interrupt requests for lines 0–12 |

## Verification
The assertions check four things on every clock. A cleared pending bit stays clear unless a detection hits it in the same cycle. A detection always lands in the pending register, even when a clear arrives with it. Each detector fires only on a pin state that matches its style. Reserved codes never fire. The bench scenarios cover what the assertions do not. They show the three-edge latency from pin to pending bit, the register layout and read-back masking, and the difference between a level style that keeps setting its bit and an edge style that sets it once. They also show that a line above 12 latches a pending bit but never reaches `irq`.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    STY_HIGH = 3'd0,
    STY_LOW  = 3'd1,
    STY_RISE = 3'd2,
    STY_FALL = 3'd3,
    STY_ANY  = 3'd4
  } style_e;

  localparam int STYLE_W = 3;
  localparam logic [5:0] OFF_OUT  = 6'h00;
  localparam logic [5:0] OFF_DIR  = 6'h04;
  localparam logic [5:0] OFF_IN   = 6'h08;
  localparam logic [5:0] OFF_PEND = 6'h0C;
  localparam logic [5:0] OFF_STY0 = 6'h10;
  localparam logic [5:0] OFF_CKS  = 6'h18;
  localparam logic [5:0] OFF_FLT  = 6'h1C;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_now,
  output logic [W-1:0] sync_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q    <= '0;
      sync_now  <= '0;
      sync_prev <= '0;
    end else begin
      meta_q    <= async_in;
      sync_now  <= meta_q;
      sync_prev <= sync_now;
    end
  end
endmodule

// File: rtl/pio_line_detect.sv
module pio_line_detect
  import pio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STYLE_W-1:0] style,
  input  logic               cur,
  input  logic               prev,
  output logic               hit
);
  always_comb begin
    case (style)
      STY_HIGH: hit = cur;
      STY_LOW:  hit = !cur;
      STY_RISE: hit = cur && !prev;
      STY_FALL: hit = !cur && prev;
      STY_ANY:  hit = cur ^ prev;
      default:  hit = 1'b0;
    endcase
  end

  // R8: reserved codes stay silent
  a_r8_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (style > 3'd4) |-> !hit);
  // R7: a rising-edge hit needs a low-to-high step
  a_r7_rise_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && style == 3'd2) |-> (cur && !prev));
  // R7: a falling-edge hit needs a high-to-low step
  a_r7_fall_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && style == 3'd3) |-> (!cur && prev));
  // R6: level styles fire only in their active level
  a_r6_level_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && style <= 3'd1) |-> (cur == (style == 3'd0)));
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl
  import pio_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int NIRQ   = 13,
  parameter int LPR    = 8,
  parameter int AW     = 6,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic [NIRQ-1:0]   irq
);
  localparam int NSTY = NLINES / LPR;
  localparam int TW   = LPR * STYLE_W;

  logic [NLINES-1:0] out_q, dir_q, pend_q;
  logic [TW-1:0]     sty_q [NSTY];
  logic [DW-1:0]     cks_q, flt_q;
  logic [NLINES-1:0] sync_now, sync_prev, hit_vec, clr_vec;

  pio_sync #(.W(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in),
    .sync_now(sync_now), .sync_prev(sync_prev)
  );

  for (genvar n = 0; n < NLINES; n++) begin : g_line
    pio_line_detect u_det (
      .clk(clk), .rst_n(rst_n),
      .style(sty_q[n / LPR][(n % LPR) * STYLE_W +: STYLE_W]),
      .cur(sync_now[n]), .prev(sync_prev[n]), .hit(hit_vec[n])
    );
  end

  assign clr_vec = (bus_wr && bus_addr == OFF_PEND) ? bus_wdata[NLINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      pend_q <= '0;
      cks_q  <= '0;
      flt_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | hit_vec;
      if (bus_wr) begin
        if (bus_addr == OFF_OUT) out_q <= bus_wdata[NLINES-1:0];
        if (bus_addr == OFF_DIR) dir_q <= bus_wdata[NLINES-1:0];
        if (bus_addr == OFF_CKS) cks_q <= bus_wdata;
        if (bus_addr == OFF_FLT) flt_q <= bus_wdata;
      end
    end
  end

  for (genvar k = 0; k < NSTY; k++) begin : g_sty
    localparam logic [AW-1:0] OFFK = AW'(OFF_STY0 + 4 * k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sty_q[k] <= '0;
      else if (bus_wr && bus_addr == OFFK) sty_q[k] <= bus_wdata[TW-1:0];
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFF_OUT:  rd_mux[NLINES-1:0] = out_q;
      OFF_DIR:  rd_mux[NLINES-1:0] = dir_q;
      OFF_IN:   rd_mux[NLINES-1:0] = sync_now;
      OFF_PEND: rd_mux[NLINES-1:0] = pend_q;
      OFF_CKS:  rd_mux = cks_q;
      OFF_FLT:  rd_mux = flt_q;
      default:  rd_mux = '0;
    endcase
    for (int k = 0; k < NSTY; k++)
      if (bus_addr == AW'(OFF_STY0 + 4 * k)) rd_mux = DW'(sty_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;
  assign irq     = pend_q[NIRQ-1:0];

  // R9: a cleared bit with no hit that cycle is gone afterwards
  a_r9_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~hit_vec) != '0) |=> ((pend_q & $past(clr_vec & ~hit_vec)) == '0));
  // R9: a detection always lands, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> ((pend_q & $past(hit_vec)) == $past(hit_vec)));
  // R10: pending bits rise only through a detection
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(hit_vec)) == '0);
endmodule

// File: tb/tb_pio_irq_ctrl.sv
module tb_pio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe;
  logic [12:0] irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] expq[$];
  string       tagq[$];
  logic        rd_fire = 1'b0;

  always #2 clk = ~clk;

  pio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    expq.push_back(e); tagq.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) rd_fire <= bus_rd;

  always @(negedge clk) begin
    if (rd_fire) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        check(tagq.pop_front(), bus_rdata, expq.pop_front());
      end
    end
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", 32'(irq), 0);
    check("R1 pad_oe", 32'(pad_oe), 0);
    rd(6'h00, 0, "R1 out");
    rd(6'h04, 32'hFFFF, "R1 dir");
    rd(6'h0C, 0, "R1 pend");
    rd(6'h10, 0, "R1 sty0");
    rd(6'h14, 0, "R1 sty1");
    rd(6'h18, 0, "R1 cks");

    // R3 direction and output
    wr(6'h00, 32'hA5A5);
    wr(6'h04, 32'hFF00);
    @(negedge clk);
    check("R3 pad_oe", 32'(pad_oe), 32'h00FF);
    check("R3 pad_out", 32'(pad_out), 32'hA5A5);
    rd(6'h04, 32'hFF00, "R3 dir readback");

    // R11 plain storage, R2 unmapped offset
    wr(6'h18, 32'h12345678);
    wr(6'h1C, 32'hCAFE0001);
    rd(6'h18, 32'h12345678, "R11 cks");
    rd(6'h1C, 32'hCAFE0001, "R11 flt");
    rd(6'h20, 0, "R2 unmapped");
    rd(6'h3C, 0, "R2 unmapped high");

    // R5 masking, R8 reserved codes silent
    wr(6'h10, 32'hFFFFFFFF);
    wr(6'h14, 32'hFFFFFFFF);
    rd(6'h10, 32'h00FFFFFF, "R5 sty0 mask");
    pad_in = 16'hFFFF; settle();
    pad_in = 16'h0000; settle();
    rd(6'h0C, 0, "R8 reserved silent");

    // R4 input view, writes ignored
    pad_in = 16'h0010; settle();
    wr(6'h08, 32'hFFFF);
    rd(6'h08, 32'h0010, "R4 input view");

    // line0 rise, line1 fall, line2 any, line3 high, line4 low, rest 7
    wr(6'h10, 32'h00FF911A);
    wr(6'h14, 32'h00FD2FFF);
    rd(6'h14, 32'h00FD2FFF, "R5 sty1 layout");
    wr(6'h0C, 32'hFFFF);
    rd(6'h0C, 0, "R9 clean start");

    // R4 latency: pending rises on the third edge after the pin
    @(negedge clk); pad_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 not before third edge", 32'(irq), 0);
    @(negedge clk);
    check("R4 third edge", 32'(irq), 32'h1);
    wr(6'h0C, 32'h1);
    @(negedge clk);
    check("R9 w1c", 32'(irq), 0);
    pad_in[0] = 1'b0; settle();
    check("R7 rise ignores fall", 32'(irq), 0);

    pad_in[1] = 1'b1; settle();
    check("R7 fall ignores rise", 32'(irq), 0);
    pad_in[1] = 1'b0; settle();
    check("R7 fall", 32'(irq), 32'h2);
    wr(6'h0C, 32'h0);
    rd(6'h0C, 32'h2, "R9 write0 keeps");
    wr(6'h0C, 32'h2);

    pad_in[2] = 1'b1; settle();
    check("R7 any rise", 32'(irq), 32'h4);
    wr(6'h0C, 32'h4); @(negedge clk);
    check("R7 edge sets once", 32'(irq), 0);
    pad_in[2] = 1'b0; settle();
    check("R7 any fall", 32'(irq), 32'h4);
    wr(6'h0C, 32'h4);

    // R6 level styles
    pad_in[3] = 1'b1; settle();
    wr(6'h0C, 32'h8); @(negedge clk);
    check("R6 high persists", 32'(irq), 32'h8);
    pad_in[3] = 1'b0; settle();
    wr(6'h0C, 32'h8); @(negedge clk);
    check("R6 high cleared", 32'(irq), 0);
    pad_in[4] = 1'b0; settle();
    check("R6 low", 32'(irq), 32'h10);
    pad_in[4] = 1'b1; settle();
    wr(6'h0C, 32'h10); @(negedge clk);
    check("R6 low cleared", 32'(irq), 0);

    // R10 irq range
    pad_in[12] = 1'b1; settle();
    check("R10 line12 irq", 32'(irq), 32'h1000);
    pad_in[13] = 1'b1; settle();
    check("R10 line13 no irq", 32'(irq), 32'h1000);
    rd(6'h0C, 32'h3000, "R10 line13 pending");
    check("R3 pads still", 32'(pad_oe), 32'h00FF);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule